// File: doc/BRIEF.md
# Line Feed-Forward Current Reference Generator

This block produces the current command for the inner loop of a boost power-factor stage, once per control sample. On each accepted sample it takes the instantaneous rectified line value, the output of the outer voltage controller and the per-period line average. All three are unsigned Q15 values, where 0 to 32767 stands for 0 to 1 per unit. It then returns a reference shaped like the rectified line. The reference is scaled by the voltage controller and divided by the square of a term that follows the RMS line level. Because of this, input power at a given controller level does not change when the line moves.

The raw average can reach only 2/π of the peak, so the block first stretches it by π/2 to its own full scale. It then forms the inverse of that value relative to the minimum-line ratio Vmin/Vmax. The inverse equals exactly 1.0 at minimum line and saturates below it. The block squares the inverse and multiplies the line sample, the controller output, the squared inverse and a fixed gain Km = Vmax/Vmin. A restoring divider computes the inverse one quotient bit per cycle.

A small state machine sequences the work. From S_IDLE, an accepted sample strobe loads the divider and moves to S_DIV. S_DIV runs one quotient bit per cycle and moves to S_SQUARE after the fifteenth bit. S_SQUARE forms the squared inverse and the sample-times-controller product. S_MIX multiplies those two. S_GAIN applies Km, raises the output strobe and returns to S_IDLE.

Top module: `ffr_refgen`

## Requirements
- R1: While reset is asserted and after its release, `ref_out` is 0 and `ref_valid` is 0 until the first result.
- R2: `ref_valid` rises exactly 18 clock edges after the edge that accepts `sample_valid`, and stays high for a single cycle.
- R3: While a computation is in progress, `sample_valid` is ignored. The next result belongs to the accepted sample, and no extra strobe follows.
- R4: The average is rescaled as n = min(32767, (line_avg × 25736) >> 14). Here 25736 is π/2 in unsigned Q2.14.
- R5: The inverse is floor(8787 × 32768 / n), where 8787 is Vmin/Vmax in Q15. It saturates to 32767 whenever n ≤ 8787, which includes n = 0.
- R6: Each product of two Q15 values keeps bits [30:15] of its 32-bit result. The squared term is c = (inv × inv) >> 15, and the partial products are ab = (sample × vloop) >> 15 and abc = (ab × c) >> 15.
- R7: The final result is min(32767, (abc × 30544) >> 13). Here 30544 is Km ≈ 3.7286 in unsigned Q3.13. The output never exceeds 32767.
- R8: `ref_out` holds its value between result strobes.
- R9: A zero line sample or a zero controller output gives `ref_out` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_valid | input | 1 | New sample strobe |
| line_sample | input | 16 | Rectified line value, unsigned Q15 |
| vloop_out | input | 16 | Voltage controller output, unsigned Q15 |
| line_avg | input | 16 | Per-period line average, unsigned Q15 |
| ref_valid | output | 1 | One-cycle result strobe |
| ref_out | output | 16 | Current reference, unsigned Q15 |

## Verification
The assertions assume that every input stays within unsigned Q15 (at most 32767). They also assume that the interval between accepted sample strobes is at least the 18-cycle latency plus one, except where a strobe is deliberately sent during a computation to exercise R3. The stimulus draws every input with a modulo of 32768. The bench waits for each result before it issues the next strobe. The busy-time strobe is injected only inside the directed R3 case. Directed values sit on both sides of the saturation point of the inverse (line_avg 5594 and 5595), at zero average and at full scale.

// File: rtl/ffr_pkg.sv
package ffr_pkg;
    localparam int DW      = 16;          // data word width
    localparam int QW      = 15;          // fraction bits, also quotient bits
    localparam int LATENCY = QW + 3;      // accept edge to result edge

    typedef enum logic [2:0] {
        S_IDLE,
        S_DIV,
        S_SQUARE,
        S_MIX,
        S_GAIN
    } ffr_state_e;
endpackage

// File: rtl/ffr_qmul.sv
// Unsigned fixed-point multiply, right shift and clamp.
module ffr_qmul #(
    parameter int AW  = 16,
    parameter int BW  = 16,
    parameter int SH  = 15,
    parameter int OW  = 16,
    parameter logic [OW-1:0] MAXV = '1
) (
    input  logic [AW-1:0] a,
    input  logic [BW-1:0] b,
    output logic [OW-1:0] y
);
    localparam int PW = AW + BW;

    logic [PW-1:0] prod;
    logic [PW-1:0] shifted;

    always_comb begin
        prod    = PW'(a) * PW'(b);
        shifted = prod >> SH;
        if (shifted > {{(PW-OW){1'b0}}, MAXV})
            y = MAXV;
        else
            y = shifted[OW-1:0];
    end
endmodule

// File: rtl/ffr_div.sv
// Restoring divider: one quotient bit per step. It requires num < den.
module ffr_div #(
    parameter int DW = 16,
    parameter int QW = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic [DW-1:0] num,
    input  logic [DW-1:0] den,
    output logic [QW-1:0] quo
);
    logic [DW-1:0] rem_q;
    logic [DW-1:0] den_q;
    logic [DW:0]   trial;
    logic          fits;

    always_comb begin
        trial = {rem_q, 1'b0};
        fits  = (trial >= {1'b0, den_q});
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
            den_q <= '0;
            quo   <= '0;
        end else if (load) begin
            rem_q <= num;
            den_q <= den;
            quo   <= '0;
        end else if (step) begin
            if (fits) begin
                rem_q <= DW'(trial - {1'b0, den_q});
                quo   <= {quo[QW-2:0], 1'b1};
            end else begin
                rem_q <= DW'(trial);
                quo   <= {quo[QW-2:0], 1'b0};
            end
        end
    end
endmodule

// File: rtl/ffr_refgen.sv
module ffr_refgen #(
    parameter int               DW     = ffr_pkg::DW,
    parameter int               QW     = ffr_pkg::QW,
    parameter logic [DW-1:0]    PIHALF = 16'd25736,   // pi/2, Q2.14
    parameter logic [DW-1:0]    RATIO  = 16'd8787,    // Vmin/Vmax, Q15
    parameter logic [DW-1:0]    KM     = 16'd30544    // Vmax/Vmin, Q3.13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sample_valid,
    input  logic [DW-1:0] line_sample,
    input  logic [DW-1:0] vloop_out,
    input  logic [DW-1:0] line_avg,
    output logic          ref_valid,
    output logic [DW-1:0] ref_out
);
    import ffr_pkg::*;

    localparam int            CW   = $clog2(QW);
    localparam logic [DW-1:0] QMAX = DW'((1 << QW) - 1);
    localparam int            GSH  = QW - 2;           // Q3.13 shift

    ffr_state_e state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic [DW-1:0] a_q, b_q, navg_q;
    logic [DW-1:0] ab_q, c_q, abc_q;

    logic [DW-1:0] navg_w, inv_w, c_w, ab_w, abc_w, ref_w;
    logic [QW-1:0] quo_w;
    logic          accept, load_w, step_w;

    assign accept = (state_q == S_IDLE) && sample_valid;
    assign load_w = accept;
    assign step_w = (state_q == S_DIV);

    // rescale average to its own full scale (saturating)
    ffr_qmul #(.AW(DW), .BW(DW), .SH(QW-1), .OW(DW), .MAXV(QMAX)) u_norm (
        .a(line_avg), .b(PIHALF), .y(navg_w)
    );

    ffr_div #(.DW(DW), .QW(QW)) u_div (
        .clk(clk), .rst_n(rst_n), .load(load_w), .step(step_w),
        .num(RATIO), .den(navg_w), .quo(quo_w)
    );

    assign inv_w = (navg_q <= RATIO) ? QMAX : {{(DW-QW){1'b0}}, quo_w};

    ffr_qmul #(.AW(DW), .BW(DW), .SH(QW), .OW(DW), .MAXV(QMAX)) u_sq (
        .a(inv_w), .b(inv_w), .y(c_w)
    );
    ffr_qmul #(.AW(DW), .BW(DW), .SH(QW), .OW(DW), .MAXV(QMAX)) u_ab (
        .a(a_q), .b(b_q), .y(ab_w)
    );
    ffr_qmul #(.AW(DW), .BW(DW), .SH(QW), .OW(DW), .MAXV(QMAX)) u_abc (
        .a(ab_q), .b(c_q), .y(abc_w)
    );
    ffr_qmul #(.AW(DW), .BW(DW), .SH(GSH), .OW(DW), .MAXV(QMAX)) u_gain (
        .a(abc_q), .b(KM), .y(ref_w)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (sample_valid) state_d = S_DIV;
            S_DIV:    if (cnt_q == CW'(QW-1)) state_d = S_SQUARE;
            S_SQUARE: state_d = S_MIX;
            S_MIX:    state_d = S_GAIN;
            S_GAIN:   state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            a_q    <= '0;
            b_q    <= '0;
            navg_q <= '0;
            ab_q   <= '0;
            c_q    <= '0;
            abc_q  <= '0;
        end else begin
            if (accept) begin
                a_q    <= line_sample;
                b_q    <= vloop_out;
                navg_q <= navg_w;
                cnt_q  <= '0;
            end
            if (state_q == S_DIV)    cnt_q <= cnt_q + 1'b1;
            if (state_q == S_SQUARE) begin
                c_q  <= c_w;
                ab_q <= ab_w;
            end
            if (state_q == S_MIX)    abc_q <= abc_w;
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_valid <= 1'b0;
            ref_out   <= '0;
        end else begin
            ref_valid <= (state_q == S_GAIN);
            if (state_q == S_GAIN) ref_out <= ref_w;
        end
    end
endmodule

// File: rtl/ffr_refgen_chk.sv
module ffr_refgen_chk #(
    parameter int DW  = 16,
    parameter int LAT = 18
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sample_valid,
    input logic [DW-1:0] line_sample,
    input logic [DW-1:0] vloop_out,
    input logic          ref_valid,
    input logic [DW-1:0] ref_out
);
    localparam int CW = $clog2(LAT + 1) + 1;

    logic [CW-1:0] run_q;
    logic [DW-1:0] a_cap, b_cap;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
            a_cap <= '0;
            b_cap <= '0;
        end else if (run_q == '0) begin
            if (sample_valid) begin
                run_q <= CW'(1);
                a_cap <= line_sample;
                b_cap <= vloop_out;
            end
        end else if (run_q == CW'(LAT)) begin
            run_q <= '0;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end

    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q == CW'(LAT)) |=> ref_valid);
    assert_no_early_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ref_valid |-> ($past(run_q) == CW'(LAT)));
    assert_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ref_valid |=> !ref_valid);
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ref_out <= DW'(16'h7FFF));
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_valid |-> $stable(ref_out));
    assert_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_valid && (a_cap == '0 || b_cap == '0)) |-> (ref_out == '0));
endmodule

bind ffr_refgen ffr_refgen_chk #(.DW(DW), .LAT(ffr_pkg::LATENCY)) u_chk (
    .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid),
    .line_sample(line_sample), .vloop_out(vloop_out),
    .ref_valid(ref_valid), .ref_out(ref_out)
);

// File: tb/ffr_refgen_tb.sv
module ffr_refgen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sample_valid = 1'b0;
    logic [15:0] line_sample = '0;
    logic [15:0] vloop_out = '0;
    logic [15:0] line_avg = '0;
    logic        ref_valid;
    logic [15:0] ref_out;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    ffr_refgen u_dut (
        .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid),
        .line_sample(line_sample), .vloop_out(vloop_out), .line_avg(line_avg),
        .ref_valid(ref_valid), .ref_out(ref_out)
    );

    always #4 clk = ~clk;

    function automatic longint sat15(longint v);
        return (v > 32767) ? 32767 : v;
    endfunction

    function automatic longint exp_inv(longint avg);
        longint n = sat15((avg * 25736) >> 14);               // R4
        return (n <= 8787) ? 32767 : (8787 * 32768) / n;       // R5
    endfunction

    function automatic longint exp_ref(longint a, longint b, longint avg);
        longint inv = exp_inv(avg);
        longint c   = (inv * inv) >> 15;                       // R6
        longint ab  = (a * b) >> 15;
        longint abc = (ab * c) >> 15;
        return sat15((abc * 30544) >> 13);                     // R7
    endfunction

    task automatic check(bit ok, string req, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Issue one sample; optionally a second strobe while busy (R3).
    task automatic run(input int a, input int b, input int avg,
                       input bit busy_poke, input string req);
        int lat = 0;
        longint e = exp_ref(a, b, avg);
        @(negedge clk);
        line_sample = 16'(a); vloop_out = 16'(b); line_avg = 16'(avg);
        sample_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        sample_valid = 1'b0;
        for (int k = 0; k < 40; k++) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            if (busy_poke && lat == 5) begin
                line_sample = 16'd32767; vloop_out = 16'd32767;
                line_avg = 16'd0; sample_valid = 1'b1;
            end else begin
                sample_valid = 1'b0;
            end
            if (ref_valid) break;
        end
        check(lat == 18, "R2 latency", lat, 18);
        check(ref_out == 16'(e), req, ref_out, e);
        @(negedge clk);
        check(!ref_valid, "R2 pulse", ref_valid, 0);
        if (busy_poke) begin
            int extra = 0;
            for (int k = 0; k < 25; k++) begin
                @(negedge clk);
                if (ref_valid) extra++;
            end
            check(extra == 0, "R3 ignored strobe", extra, 0);
        end
        check(ref_out == 16'(e), "R8 hold", ref_out, e);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                errors++;
                checks++;
                $display("FAIL watchdog actual=%0d expected=<150000", cycles);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check(ref_out == 0 && ref_valid == 0, "R1 in reset", ref_out, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(ref_out == 0 && ref_valid == 0, "R1 after reset", ref_out, 0);

        run(20000, 16000, 20000, 1'b0, "R6 mid values");
        run(32767, 32767, 5594,  1'b0, "R5 inverse at ratio saturates");
        run(32767, 32767, 5595,  1'b0, "R5 inverse just above ratio");
        run(30000, 25000, 0,     1'b0, "R5 zero average saturates");
        run(32767, 32767, 32767, 1'b0, "R4 average rescale saturates");
        run(0,     32767, 6000,  1'b0, "R9 zero sample");
        run(32767, 0,     6000,  1'b0, "R9 zero controller");
        run(32767, 32767, 7000,  1'b0, "R7 gain saturates");
        run(12000, 9000,  15000, 1'b1, "R3 busy strobe ignored");

        for (int i = 0; i < 60; i++) begin
            int a   = int'($urandom % 32768);
            int b   = int'($urandom % 32768);
            int avg = int'($urandom % 32768);
            run(a, b, avg, 1'b0, "R7 random result");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule